// File: doc/BRIEF.md
# Dual-Address Synchronous RAM with Port-to-Port Forwarding

This block is a single-clock memory with two fully independent ports, called X and Y. Each port has its own address, write data, write enable, two chip enables and a forwarding control. In one cycle both ports may read, write or forward, in any combination. Every control, address and data input is registered on the rising clock edge. Results come out through a register on each port one clock later. An asynchronous output-enable per port decides whether that port drives its data output. Data-in, data-out and drive-enable are separate signals, so the block can sit behind a pad ring or connect straight to on-chip logic.

Forwarding lets a port's captured write data go straight to the other port's output register without passing through the array. It takes priority over a read on the receiving port. When both ports address the same word, the result is fixed. Two reads both return the word. A read that meets a write returns the word as it was before the write. Two writes store only port Y's data. The array depth is set by the address-width parameter and the word width by the data-width parameter. The full-size setting is 17 address bits and 36 data bits.

Top module: `dual_port_ptram`

## Requirements
- R1: All inputs except the two output enables are sampled on a rising clock edge. The resulting read or forwarded data appears at the port output after the following rising edge and not before.
- R2: A selected port with its write enable high (`we_n`=1) returns the word stored at its sampled address.
- R3: A selected port with its write enable low (`we_n`=0) stores its sampled data at its sampled address.
- R4: A port is selected only when its first chip enable is low (`ce_n`=0) and its second is high (`ce`=1). An unselected port neither reads nor writes, even with `we_n` low.
- R5: With `pt_x`=1 sampled, port X's sampled data lands in port Y's output register. With `pt_y`=1, port Y's sampled data lands in port X's output register. Chip enables have no effect on this.
- R6: Forwarding into a port overrides a read on that same port in the same cycle.
- R7: With both forwarding controls high in one cycle, the two ports' data are exchanged: X's data reaches Y's output and Y's data reaches X's output.
- R8: Two reads of the same address in one cycle both return the stored word.
- R9: When one port writes an address that the other port reads in the same cycle, the read returns the word held before the write, and the write still takes effect.
- R10: When both ports write the same address in one cycle, only port Y's data is stored.
- R11: `oe_n` high makes that port's `drv` low and its data output zero at once, with no clock needed. The output register is not disturbed, and its value returns when `oe_n` goes low again.
- R12: Synchronous reset (`rst_n`=0) clears both output registers to zero and cancels any pending operation.
- R13: A port's output register keeps its value in any cycle where it is neither forwarded into nor reading.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Synchronous active-low reset |
| addr_x | input | ADDR_W | Port X address |
| din_x | input | DATA_W | Port X write / forward data |
| ce_n_x | input | 1 | Port X chip enable, active low |
| ce_x | input | 1 | Port X chip enable, active high |
| we_n_x | input | 1 | Port X write enable, active low |
| pt_x | input | 1 | Forward port X data to port Y output |
| oe_n_x | input | 1 | Port X output enable, active low, asynchronous |
| dout_x | output | DATA_W | Port X data output (zero when not driven) |
| drv_x | output | 1 | Port X drive enable |
| addr_y | input | ADDR_W | Port Y address |
| din_y | input | DATA_W | Port Y write / forward data |
| ce_n_y | input | 1 | Port Y chip enable, active low |
| ce_y | input | 1 | Port Y chip enable, active high |
| we_n_y | input | 1 | Port Y write enable, active low |
| pt_y | input | 1 | Forward port Y data to port X output |
| oe_n_y | input | 1 | Port Y output enable, active low, asynchronous |
| dout_y | output | DATA_W | Port Y data output (zero when not driven) |
| drv_y | output | 1 | Port Y drive enable |

## Verification
Reads with different addresses on the two ports confirm that each port decodes its own address and does not mirror the other's. Same-address reads, read-against-write from each side, and a double write are each followed by readback. Every word in these cases is distinct, so an old value, a new value and a held value cannot be confused.

Forwarding is tried in three ways:
- one direction at a time, with the receiving port also reading;
- both directions at once, which separates a true exchange from a copy;
- together with a write on the sending port.

Half-selected write attempts, a one-cycle latency probe and output-enable toggling during a read round out the run.

// File: rtl/ptram_pkg.sv
package ptram_pkg;

   localparam int MAX_ADDR_W = 17;

   typedef enum logic [1:0] {
      PORT_IDLE  = 2'd0,
      PORT_READ  = 2'd1,
      PORT_WRITE = 2'd2
   } port_op_e;

endpackage

// File: rtl/ptram_capture.sv
module ptram_capture
   import ptram_pkg::*;
#(
   parameter int ADDR_W = 6,
   parameter int DATA_W = 36
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [ADDR_W-1:0] addr,
   input  logic [DATA_W-1:0] din,
   input  logic              ce_n,
   input  logic              ce,
   input  logic              we_n,
   input  logic              pt,
   output logic [ADDR_W-1:0] addr_q,
   output logic [DATA_W-1:0] din_q,
   output port_op_e          op_q,
   output logic              pt_q
);

   logic     sel;
   port_op_e op_d;

   always_comb begin
      sel = !ce_n && ce;
      if (!sel)       op_d = PORT_IDLE;
      else if (!we_n) op_d = PORT_WRITE;
      else            op_d = PORT_READ;
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         addr_q <= '0;
         din_q  <= '0;
         op_q   <= PORT_IDLE;
         pt_q   <= 1'b0;
      end else begin
         addr_q <= addr;
         din_q  <= din;
         op_q   <= op_d;
         pt_q   <= pt;
      end
   end

endmodule

// File: rtl/ptram_core.sv
module ptram_core
   import ptram_pkg::*;
#(
   parameter int ADDR_W = 6,
   parameter int DATA_W = 36
) (
   input  logic              clk,
   input  logic              rst_n,
   input  port_op_e          op_x,
   input  port_op_e          op_y,
   input  logic [ADDR_W-1:0] addr_x,
   input  logic [ADDR_W-1:0] addr_y,
   input  logic [DATA_W-1:0] din_x,
   input  logic [DATA_W-1:0] din_y,
   output logic [DATA_W-1:0] rdata_x,
   output logic [DATA_W-1:0] rdata_y
);

   localparam int DEPTH = 1 << ADDR_W;

   logic [DATA_W-1:0] mem [DEPTH];
   logic              wr_x, wr_y, same_addr, x_blocked;

   always_comb begin
      wr_x      = (op_x == PORT_WRITE);
      wr_y      = (op_y == PORT_WRITE);
      same_addr = (addr_x == addr_y);
      x_blocked = wr_y && same_addr;
   end

   // Reads sample the array before this edge's writes land (old data).
   assign rdata_x = mem[addr_x];
   assign rdata_y = mem[addr_y];

   always_ff @(posedge clk) begin
      if (wr_x && !x_blocked) mem[addr_x] <= din_x;
      if (wr_y)               mem[addr_y] <= din_y;
   end

   // R10
   y_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (op_x == PORT_WRITE && op_y == PORT_WRITE && addr_x == addr_y)
      |=> mem[$past(addr_y)] == $past(din_y));

   // R3
   x_store_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (op_x == PORT_WRITE && !(op_y == PORT_WRITE && addr_x == addr_y))
      |=> mem[$past(addr_x)] == $past(din_x));

endmodule

// File: rtl/ptram_out.sv
module ptram_out #(
   parameter int DATA_W    = 36,
   parameter bit OUT_RESET = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              fwd_sel,
   input  logic [DATA_W-1:0] fwd_data,
   input  logic              rd_en,
   input  logic [DATA_W-1:0] rd_data,
   output logic [DATA_W-1:0] q
);

   generate
      if (OUT_RESET) begin : g_rst
         always_ff @(posedge clk) begin
            if (!rst_n)       q <= '0;
            else if (fwd_sel) q <= fwd_data;
            else if (rd_en)   q <= rd_data;
         end
      end else begin : g_norst
         always_ff @(posedge clk) begin
            if (fwd_sel)    q <= fwd_data;
            else if (rd_en) q <= rd_data;
         end
      end
   endgenerate

   // R13
   idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!fwd_sel && !rd_en) |=> $stable(q));

endmodule

// File: rtl/dual_port_ptram.sv
module dual_port_ptram
   import ptram_pkg::*;
#(
   parameter int ADDR_W    = 6,
   parameter int DATA_W    = 36,
   parameter bit OUT_RESET = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [ADDR_W-1:0] addr_x,
   input  logic [DATA_W-1:0] din_x,
   input  logic              ce_n_x,
   input  logic              ce_x,
   input  logic              we_n_x,
   input  logic              pt_x,
   input  logic              oe_n_x,
   output logic [DATA_W-1:0] dout_x,
   output logic              drv_x,
   input  logic [ADDR_W-1:0] addr_y,
   input  logic [DATA_W-1:0] din_y,
   input  logic              ce_n_y,
   input  logic              ce_y,
   input  logic              we_n_y,
   input  logic              pt_y,
   input  logic              oe_n_y,
   output logic [DATA_W-1:0] dout_y,
   output logic              drv_y
);

   generate
      if (ADDR_W < 1 || ADDR_W > MAX_ADDR_W) begin : g_bad_addr
         $error("dual_port_ptram: ADDR_W out of range");
      end
      if (DATA_W < 1) begin : g_bad_data
         $error("dual_port_ptram: DATA_W must be positive");
      end
   endgenerate

   logic [ADDR_W-1:0] ax_q, ay_q;
   logic [DATA_W-1:0] dx_q, dy_q, rx, ry, qx, qy;
   port_op_e          opx_q, opy_q;
   logic              ptx_q, pty_q;

   ptram_capture #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_cap_x (
      .clk(clk), .rst_n(rst_n), .addr(addr_x), .din(din_x), .ce_n(ce_n_x),
      .ce(ce_x), .we_n(we_n_x), .pt(pt_x),
      .addr_q(ax_q), .din_q(dx_q), .op_q(opx_q), .pt_q(ptx_q));

   ptram_capture #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_cap_y (
      .clk(clk), .rst_n(rst_n), .addr(addr_y), .din(din_y), .ce_n(ce_n_y),
      .ce(ce_y), .we_n(we_n_y), .pt(pt_y),
      .addr_q(ay_q), .din_q(dy_q), .op_q(opy_q), .pt_q(pty_q));

   ptram_core #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_core (
      .clk(clk), .rst_n(rst_n), .op_x(opx_q), .op_y(opy_q),
      .addr_x(ax_q), .addr_y(ay_q), .din_x(dx_q), .din_y(dy_q),
      .rdata_x(rx), .rdata_y(ry));

   // Port X output receives Y's forwarded data, and vice versa.
   ptram_out #(.DATA_W(DATA_W), .OUT_RESET(OUT_RESET)) u_out_x (
      .clk(clk), .rst_n(rst_n), .fwd_sel(pty_q), .fwd_data(dy_q),
      .rd_en(opx_q == PORT_READ), .rd_data(rx), .q(qx));

   ptram_out #(.DATA_W(DATA_W), .OUT_RESET(OUT_RESET)) u_out_y (
      .clk(clk), .rst_n(rst_n), .fwd_sel(ptx_q), .fwd_data(dx_q),
      .rd_en(opy_q == PORT_READ), .rd_data(ry), .q(qy));

   assign drv_x  = !oe_n_x;
   assign drv_y  = !oe_n_y;
   assign dout_x = drv_x ? qx : '0;
   assign dout_y = drv_y ? qy : '0;

   // R5
   fwd_x_to_y_chk: assert property (@(posedge clk) disable iff (!rst_n)
      pt_x |=> ##1 (oe_n_y || dout_y == $past(din_x, 2)));

   // R5
   fwd_y_to_x_chk: assert property (@(posedge clk) disable iff (!rst_n)
      pt_y |=> ##1 (oe_n_x || dout_x == $past(din_y, 2)));

endmodule

// File: tb/tb_dual_port_ptram.sv
module tb_dual_port_ptram;

   localparam int AW = 6;
   localparam int DW = 36;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic [AW-1:0] addr_x = '0, addr_y = '0;
   logic [DW-1:0] din_x = '0, din_y = '0;
   logic          ce_n_x = 1'b1, ce_x = 1'b0, we_n_x = 1'b1, pt_x = 1'b0, oe_n_x = 1'b0;
   logic          ce_n_y = 1'b1, ce_y = 1'b0, we_n_y = 1'b1, pt_y = 1'b0, oe_n_y = 1'b0;
   logic [DW-1:0] dout_x, dout_y;
   logic          drv_x, drv_y;

   int checks = 0;
   int errors = 0;
   bit done   = 1'b0;

   always #2 clk = ~clk;

   dual_port_ptram #(.ADDR_W(AW), .DATA_W(DW)) dut (
      .clk(clk), .rst_n(rst_n),
      .addr_x(addr_x), .din_x(din_x), .ce_n_x(ce_n_x), .ce_x(ce_x), .we_n_x(we_n_x),
      .pt_x(pt_x), .oe_n_x(oe_n_x), .dout_x(dout_x), .drv_x(drv_x),
      .addr_y(addr_y), .din_y(din_y), .ce_n_y(ce_n_y), .ce_y(ce_y), .we_n_y(we_n_y),
      .pt_y(pt_y), .oe_n_y(oe_n_y), .dout_y(dout_y), .drv_y(drv_y));

   // op codes: 0 idle (ce_n=1), 1 read, 2 write, 3 half-selected write (ce=0, we_n=0)
   typedef struct packed {
      logic [4:0]    req;
      logic [AW-1:0] ax;
      logic [AW-1:0] ay;
      logic [DW-1:0] dx;
      logic [DW-1:0] dy;
      logic [1:0]    opx;
      logic [1:0]    opy;
      logic          ptx;
      logic          pty;
      logic [DW-1:0] ex;
      logic [DW-1:0] ey;
   } vec_t;

   localparam int NV = 17;
   localparam vec_t VECS [NV] = '{
      // R3 write both ports, outputs stay at reset value
      '{5'd3,  6'd1,  6'd2,  36'hA_0000_00A1, 36'hB_0000_00B2, 2'd2, 2'd2, 1'b0, 1'b0, 36'h0, 36'h0},
      // R2 cross reads
      '{5'd2,  6'd2,  6'd1,  36'h0, 36'h0, 2'd1, 2'd1, 1'b0, 1'b0, 36'hB_0000_00B2, 36'hA_0000_00A1},
      // R8 same-address double read
      '{5'd8,  6'd2,  6'd2,  36'h0, 36'h0, 2'd1, 2'd1, 1'b0, 1'b0, 36'hB_0000_00B2, 36'hB_0000_00B2},
      // R9 X writes, Y reads old; X holds (R13)
      '{5'd9,  6'd1,  6'd1,  36'hC_0000_00C3, 36'h0, 2'd2, 2'd1, 1'b0, 1'b0, 36'hB_0000_00B2, 36'hA_0000_00A1},
      // R9 write landed afterwards
      '{5'd9,  6'd1,  6'd0,  36'h0, 36'h0, 2'd1, 2'd0, 1'b0, 1'b0, 36'hC_0000_00C3, 36'hA_0000_00A1},
      // R9 Y writes, X reads old
      '{5'd9,  6'd1,  6'd1,  36'h0, 36'hD_0000_00D5, 2'd1, 2'd2, 1'b0, 1'b0, 36'hC_0000_00C3, 36'hA_0000_00A1},
      // R10 double write same address
      '{5'd10, 6'd3,  6'd3,  36'hE_0000_00E6, 36'hF_0000_00F6, 2'd2, 2'd2, 1'b0, 1'b0, 36'hC_0000_00C3, 36'hA_0000_00A1},
      // R10 Y data stored
      '{5'd10, 6'd3,  6'd3,  36'h0, 36'h0, 2'd1, 2'd1, 1'b0, 1'b0, 36'hF_0000_00F6, 36'hF_0000_00F6},
      // R6 X forwards to Y over Y's read
      '{5'd6,  6'd0,  6'd2,  36'h1_2300_0123, 36'h0, 2'd0, 2'd1, 1'b1, 1'b0, 36'hF_0000_00F6, 36'h1_2300_0123},
      // R5 Y forwards to X over X's read
      '{5'd5,  6'd2,  6'd0,  36'h0, 36'h4_5600_0456, 2'd1, 2'd0, 1'b0, 1'b1, 36'h4_5600_0456, 36'h1_2300_0123},
      // R7 exchange, both also reading
      '{5'd7,  6'd1,  6'd1,  36'h1_1100_0111, 36'h2_2200_0222, 2'd1, 2'd1, 1'b1, 1'b1, 36'h2_2200_0222, 36'h1_1100_0111},
      // R4 half-selected writes ignored
      '{5'd4,  6'd2,  6'd1,  36'h9_9900_0999, 36'h8_8800_0888, 2'd3, 2'd3, 1'b0, 1'b0, 36'h2_2200_0222, 36'h1_1100_0111},
      // R4 readback shows no change
      '{5'd4,  6'd2,  6'd1,  36'h0, 36'h0, 2'd1, 2'd1, 1'b0, 1'b0, 36'hB_0000_00B2, 36'hD_0000_00D5},
      // R3 top address, all ones
      '{5'd3,  6'd63, 6'd0,  36'hF_FFFF_FFFF, 36'h0, 2'd2, 2'd0, 1'b0, 1'b0, 36'hB_0000_00B2, 36'hD_0000_00D5},
      // R2 top address readback
      '{5'd2,  6'd63, 6'd63, 36'h0, 36'h0, 2'd1, 2'd1, 1'b0, 1'b0, 36'hF_FFFF_FFFF, 36'hF_FFFF_FFFF},
      // R5 forward while writing
      '{5'd5,  6'd5,  6'd0,  36'h5_5500_0555, 36'h0, 2'd2, 2'd0, 1'b1, 1'b0, 36'hF_FFFF_FFFF, 36'h5_5500_0555},
      // R3 forwarded write also stored
      '{5'd3,  6'd5,  6'd0,  36'h0, 36'h0, 2'd1, 2'd0, 1'b0, 1'b0, 36'h5_5500_0555, 36'h5_5500_0555}
   };

   function automatic logic [2:0] ctl(input logic [1:0] op); // {ce_n, ce, we_n}
      case (op)
         2'd1:    return 3'b011;
         2'd2:    return 3'b010;
         2'd3:    return 3'b000;
         default: return 3'b101;
      endcase
   endfunction

   task automatic check(input int req, input logic [DW-1:0] act, input logic [DW-1:0] exp,
                        input string what);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL R%0d %s: actual %h expected %h", req, what, act, exp);
      end
   endtask

   task automatic go_idle();
      {ce_n_x, ce_x, we_n_x} = 3'b101;
      {ce_n_y, ce_y, we_n_y} = 3'b101;
      pt_x = 1'b0;
      pt_y = 1'b0;
   endtask

   task automatic drive(input vec_t v);
      addr_x = v.ax; addr_y = v.ay; din_x = v.dx; din_y = v.dy;
      {ce_n_x, ce_x, we_n_x} = ctl(v.opx);
      {ce_n_y, ce_y, we_n_y} = ctl(v.opy);
      pt_x = v.ptx; pt_y = v.pty;
   endtask

   task automatic finish_run();
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   endtask

   initial begin
      #(4 * 20000);
      if (!done) begin
         checks++;
         errors++;
         $display("FAIL watchdog: actual timeout expected completion");
         finish_run();
      end
   end

   initial begin
      repeat (3) @(posedge clk);
      @(negedge clk);
      // R12 reset state
      check(12, dout_x, '0, "reset dout_x");
      check(12, dout_y, '0, "reset dout_y");
      check(11, {35'd0, drv_x}, 36'd1, "drv_x with oe_n low");
      rst_n = 1'b1;

      for (int i = 0; i < NV; i++) begin
         @(negedge clk);
         drive(VECS[i]);
         @(posedge clk);
         @(negedge clk);
         go_idle();
         @(posedge clk);
         @(negedge clk);
         check(VECS[i].req, dout_x, VECS[i].ex, $sformatf("vector %0d port X", i));
         check(VECS[i].req, dout_y, VECS[i].ey, $sformatf("vector %0d port Y", i));
      end

      // R1 latency: nothing visible after the sampling edge, result after the next
      drive('{5'd1, 6'd2, 6'd0, 36'h0, 36'h0, 2'd1, 2'd0, 1'b0, 1'b0, 36'h0, 36'h0});
      @(posedge clk);
      @(negedge clk);
      go_idle();
      check(1, dout_x, 36'h5_5500_0555, "before second edge");
      @(posedge clk);
      @(negedge clk);
      check(1, dout_x, 36'hB_0000_00B2, "after second edge");

      // R13 several idle cycles hold the outputs
      repeat (3) @(posedge clk);
      @(negedge clk);
      check(13, dout_x, 36'hB_0000_00B2, "idle hold X");
      check(13, dout_y, 36'h5_5500_0555, "idle hold Y");

      // R11 output enable acts without a clock and leaves the register alone
      oe_n_x = 1'b1;
      #0.5;
      check(11, {35'd0, drv_x}, 36'd0, "drv_x off");
      check(11, dout_x, '0, "dout_x gated");
      check(11, dout_y, 36'h5_5500_0555, "dout_y unaffected");
      @(negedge clk);
      drive('{5'd11, 6'd63, 6'd0, 36'h0, 36'h0, 2'd1, 2'd0, 1'b0, 1'b0, 36'h0, 36'h0});
      @(posedge clk);
      @(negedge clk);
      go_idle();
      @(posedge clk);
      @(negedge clk);
      check(11, dout_x, '0, "still gated after read");
      oe_n_x = 1'b0;
      #0.5;
      check(11, {35'd0, drv_x}, 36'd1, "drv_x back on");
      check(11, dout_x, 36'hF_FFFF_FFFF, "read value under gate");

      // R12 reset in mid-run clears output registers
      @(negedge clk);
      rst_n = 1'b0;
      @(posedge clk);
      @(negedge clk);
      check(12, dout_x, '0, "mid-run reset X");
      check(12, dout_y, '0, "mid-run reset Y");

      done = 1'b1;
      finish_run();
   end

endmodule